// File: doc/BRIEF.md
# Compare-and-Branch Fusing Decode Front End

This block sits between an instruction queue and four parallel decode slots. Each cycle it looks at a window of up to five instruction records, in program order. Each record carries a two-bit operation class, two operand fields and a branch-target field. The block assigns the records to the slots in order and returns to the queue the number of records it consumed.

When a compare or test record is followed at once by a conditional branch, the block merges the two into a single fused micro-op. That micro-op takes one slot and carries the compare's operands together with the branch's target. A fused pair therefore lets five records leave the queue in one cycle through four slots. At most one pair is fused per cycle, in any slot.

A compare that is the last visible record, with its branch not yet in the window, normally decodes alone. Setting the `HOLD_BACK` parameter makes the block leave such a compare in the queue for one accepted cycle, so its branch can arrive and fuse. Downstream backpressure (`outReady` low) stalls consumption and leaves the presented micro-ops unchanged.

Top module: `fuse_decode`

## Requirements
- R1: Occupied slots are packed from slot 0 upward, and slot order follows window order (window position 0 is oldest).
- R2: Fusion happens only when position i holds class CMP (2'b01) or TEST (2'b10), position i+1 holds class JCC (2'b11), and both positions are valid. Class PLAIN is 2'b00. A branch before a compare, or any other pairing, is not fused.
- R3: A fused micro-op sets its fused flag. Its class, operand A and operand B come from the compare record, and its target comes from the branch record. An unfused micro-op takes every field from its own record.
- R4: At most one fusion is formed per cycle, and it is the earliest eligible pair. A later eligible pair in the same cycle decodes as two plain micro-ops.
- R5: While `outReady` is high, `takeCount` equals the number of valid slots plus one if a fusion occurred. Its maximum is 5 with fusion and 4 without.
- R6: With `HOLD_BACK`=0, a compare or test in the last visible position decodes alone as a plain micro-op.
- R7: With `HOLD_BACK`=1, such a last-visible compare is left unconsumed and produces no micro-op. In the next accepted cycle it decodes alone if it is still unpaired, and it fuses if its branch has arrived.
- R8: While `outReady` is low, `takeCount` is 0 and the hold-back state is unchanged. With a stable window, the presented micro-ops also stay stable.
- R9: Entries at and after the first invalid window position are ignored. After reset, an empty window gives no micro-ops and a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | SLOTS+1 | Per-position valid bit of the queue window |
| inCls | input | 2*(SLOTS+1) | Class of each window record, 2 bits per position |
| inOpA | input | (SLOTS+1)*OPW | Operand A per window record |
| inOpB | input | (SLOTS+1)*OPW | Operand B per window record |
| inTgt | input | (SLOTS+1)*TGW | Branch-target field per window record |
| outReady | input | 1 | Downstream accepts the presented micro-ops |
| uopValid | output | SLOTS | Slot carries a micro-op |
| uopFused | output | SLOTS | Slot carries a fused compare/branch micro-op |
| uopCls | output | 2*SLOTS | Class per slot |
| uopOpA | output | SLOTS*OPW | Operand A per slot |
| uopOpB | output | SLOTS*OPW | Operand B per slot |
| uopTgt | output | SLOTS*TGW | Target per slot |
| takeCount | output | clog2(SLOTS+2) | Records consumed from the queue this cycle |

## Verification
The slot assignment is combinational from the window. A wrong pointer advance or a wrong fusion decision therefore shows in the same cycle as a mismatch between `takeCount` and the valid and fused slot bits, or as operands and targets drawn from the wrong window position. The only stored state is the hold-back flag. If it is wrong, the result appears one accepted cycle later: a lone compare is either decoded when it should have waited, or held a second time, which would starve the queue.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

  typedef enum logic [1:0] {
    CLS_PLAIN = 2'd0,
    CLS_CMP   = 2'd1,
    CLS_TEST  = 2'd2,
    CLS_JCC   = 2'd3
  } opClass_t;

  // Width of a slot's source index; covers windows of up to eight entries.
  localparam int SRC_W = 3;

  typedef struct packed {
    logic             valid;
    logic             fused;
    logic [SRC_W-1:0] src;
  } slotStrobe_t;

endpackage

// File: rtl/fuse_ctrl.sv
module fuse_ctrl
  import fuse_pkg::*;
#(
  parameter int SLOTS     = 4,
  parameter int HOLD_BACK = 0
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [SLOTS:0]                winValid,
  input  logic [2*SLOTS+1:0]            winCls,
  input  logic                          outReady,
  output slotStrobe_t                   strobes [SLOTS],
  output logic [$clog2(SLOTS+2)-1:0]    takeCount
);

  localparam int WIN   = SLOTS + 1;
  localparam int CNT_W = $clog2(WIN + 1);

  logic holdFlag;
  logic holdTaken;
  logic [CNT_W-1:0] usedCount;

  function automatic opClass_t clsAt(input int idx);
    if (idx < WIN) return opClass_t'(winCls[2*idx +: 2]);
    return CLS_PLAIN;
  endfunction

  function automatic logic validAt(input int idx);
    if (idx < WIN) return winValid[idx];
    return 1'b0;
  endfunction

  // Walk the window in program order, filling one slot per step.
  always_comb begin
    int   ptr;
    logic fuseUsed;
    logic stopWalk;
    logic isCmp;
    logic nextVis;
    ptr       = 0;
    fuseUsed  = 1'b0;
    stopWalk  = 1'b0;
    holdTaken = 1'b0;
    isCmp     = 1'b0;
    nextVis   = 1'b0;
    for (int s = 0; s < SLOTS; s++) begin
      strobes[s] = '0;
      if (!stopWalk) begin
        if (validAt(ptr)) begin
          isCmp   = (clsAt(ptr) == CLS_CMP) || (clsAt(ptr) == CLS_TEST);
          nextVis = validAt(ptr + 1);
          if (isCmp && nextVis && (clsAt(ptr + 1) == CLS_JCC) && !fuseUsed) begin
            strobes[s].valid = 1'b1;
            strobes[s].fused = 1'b1;
            strobes[s].src   = ptr[SRC_W-1:0];
            fuseUsed         = 1'b1;
            ptr              = ptr + 2;
          end else if (isCmp && !nextVis && (HOLD_BACK != 0) && !holdFlag) begin
            holdTaken = 1'b1;
            stopWalk  = 1'b1;
          end else begin
            strobes[s].valid = 1'b1;
            strobes[s].src   = ptr[SRC_W-1:0];
            ptr              = ptr + 1;
          end
        end else begin
          stopWalk = 1'b1;
        end
      end
    end
    usedCount = ptr[CNT_W-1:0];
  end

  assign takeCount = outReady ? usedCount : '0;

  // A hold is granted once; the next accepted cycle must decode the compare.
  always_ff @(posedge clk) begin
    if (!rstN)         holdFlag <= 1'b0;
    else if (outReady) holdFlag <= holdTaken;
  end

endmodule

// File: rtl/fuse_dp.sv
module fuse_dp
  import fuse_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int OPW   = 8,
  parameter int TGW   = 12
) (
  input  slotStrobe_t               strobes [SLOTS],
  input  logic [2*SLOTS+1:0]        winCls,
  input  logic [(SLOTS+1)*OPW-1:0]  winOpA,
  input  logic [(SLOTS+1)*OPW-1:0]  winOpB,
  input  logic [(SLOTS+1)*TGW-1:0]  winTgt,
  output logic [SLOTS-1:0]          uopValid,
  output logic [SLOTS-1:0]          uopFused,
  output logic [2*SLOTS-1:0]        uopCls,
  output logic [SLOTS*OPW-1:0]      uopOpA,
  output logic [SLOTS*OPW-1:0]      uopOpB,
  output logic [SLOTS*TGW-1:0]      uopTgt
);

  localparam int WIN = SLOTS + 1;

  for (genvar s = 0; s < SLOTS; s++) begin : gLane
    always_comb begin
      int srcIdx;
      int tgtIdx;
      srcIdx = int'(strobes[s].src);
      if (srcIdx >= WIN) srcIdx = 0;
      tgtIdx = strobes[s].fused ? srcIdx + 1 : srcIdx;
      if (tgtIdx >= WIN) tgtIdx = 0;
      uopValid[s]            = strobes[s].valid;
      uopFused[s]            = strobes[s].fused;
      uopCls[2*s +: 2]       = winCls[2*srcIdx +: 2];
      uopOpA[s*OPW +: OPW]   = winOpA[srcIdx*OPW +: OPW];
      uopOpB[s*OPW +: OPW]   = winOpB[srcIdx*OPW +: OPW];
      uopTgt[s*TGW +: TGW]   = winTgt[tgtIdx*TGW +: TGW];
    end
  end

endmodule

// File: rtl/fuse_decode.sv
module fuse_decode
  import fuse_pkg::*;
#(
  parameter int SLOTS     = 4,
  parameter int OPW       = 8,
  parameter int TGW       = 12,
  parameter int HOLD_BACK = 0
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [SLOTS:0]                inValid,
  input  logic [2*SLOTS+1:0]            inCls,
  input  logic [(SLOTS+1)*OPW-1:0]      inOpA,
  input  logic [(SLOTS+1)*OPW-1:0]      inOpB,
  input  logic [(SLOTS+1)*TGW-1:0]      inTgt,
  input  logic                          outReady,
  output logic [SLOTS-1:0]              uopValid,
  output logic [SLOTS-1:0]              uopFused,
  output logic [2*SLOTS-1:0]            uopCls,
  output logic [SLOTS*OPW-1:0]          uopOpA,
  output logic [SLOTS*OPW-1:0]          uopOpB,
  output logic [SLOTS*TGW-1:0]          uopTgt,
  output logic [$clog2(SLOTS+2)-1:0]    takeCount
);

  slotStrobe_t strobes [SLOTS];

  fuse_ctrl #(.SLOTS(SLOTS), .HOLD_BACK(HOLD_BACK)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .winValid  (inValid),
    .winCls    (inCls),
    .outReady  (outReady),
    .strobes   (strobes),
    .takeCount (takeCount)
  );

  fuse_dp #(.SLOTS(SLOTS), .OPW(OPW), .TGW(TGW)) uDp (
    .strobes  (strobes),
    .winCls   (inCls),
    .winOpA   (inOpA),
    .winOpB   (inOpB),
    .winTgt   (inTgt),
    .uopValid (uopValid),
    .uopFused (uopFused),
    .uopCls   (uopCls),
    .uopOpA   (uopOpA),
    .uopOpB   (uopOpB),
    .uopTgt   (uopTgt)
  );

endmodule

// File: rtl/fuse_decode_chk.sv
module fuse_decode_chk #(
  parameter int SLOTS = 4
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [SLOTS:0]              inValid,
  input logic [2*SLOTS+1:0]          inCls,
  input logic                        outReady,
  input logic [SLOTS-1:0]            uopValid,
  input logic [SLOTS-1:0]            uopFused,
  input logic [2*SLOTS-1:0]          uopCls,
  input logic [$clog2(SLOTS+2)-1:0]  takeCount
);

  assert_packed_slots_R1: assert property (@(posedge clk) disable iff (!rstN)
    ((uopValid + 1'b1) & uopValid) == '0);

  for (genvar s = 0; s < SLOTS; s++) begin : gFuseCls
    assert_fused_is_compare_R2: assert property (@(posedge clk) disable iff (!rstN)
      uopFused[s] |-> (uopCls[2*s +: 2] == 2'd1 || uopCls[2*s +: 2] == 2'd2));
  end

  assert_fused_in_valid_slot_R3: assert property (@(posedge clk) disable iff (!rstN)
    (uopFused & ~uopValid) == '0);

  assert_single_fusion_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(uopFused));

  assert_count_matches_slots_R5: assert property (@(posedge clk) disable iff (!rstN)
    outReady |-> (int'(takeCount) == $countones(uopValid) + $countones(uopFused)));

  assert_no_take_on_stall_R8: assert property (@(posedge clk) disable iff (!rstN)
    !outReady |-> takeCount == '0);

  assert_stall_keeps_uops_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!outReady) && $stable(inValid) && $stable(inCls))
      |-> ($stable(uopValid) && $stable(uopFused)));

endmodule

bind fuse_decode fuse_decode_chk #(.SLOTS(SLOTS)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .inCls     (inCls),
  .outReady  (outReady),
  .uopValid  (uopValid),
  .uopFused  (uopFused),
  .uopCls    (uopCls),
  .takeCount (takeCount)
);

// File: tb/tb_fuse_decode.sv
module tb_fuse_decode;

  localparam int SLOTS = 4;
  localparam int WIN   = SLOTS + 1;
  localparam int OPW   = 8;
  localparam int TGW   = 12;

  typedef struct packed {
    logic [4:0]  vld;
    logic [9:0]  cls;
    logic [3:0]  eV;
    logic [3:0]  eF;
    logic [11:0] eSrc;
    logic [2:0]  eCnt;
  } vec_t;

  // Class codes: 0 plain, 1 compare, 2 test, 3 branch. cls = {p4,p3,p2,p1,p0}.
  localparam vec_t VECS [12] = '{
    '{5'b11111, {2'd0,2'd0,2'd0,2'd0,2'd0}, 4'b1111, 4'b0000, {3'd3,3'd2,3'd1,3'd0}, 3'd4}, // R1 plain
    '{5'b11111, {2'd0,2'd0,2'd0,2'd3,2'd1}, 4'b1111, 4'b0001, {3'd4,3'd3,3'd2,3'd0}, 3'd5}, // R2 fuse slot0
    '{5'b11111, {2'd3,2'd1,2'd0,2'd0,2'd0}, 4'b1111, 4'b1000, {3'd3,3'd2,3'd1,3'd0}, 3'd5}, // R4 fuse slot3
    '{5'b11111, {2'd0,2'd3,2'd2,2'd3,2'd1}, 4'b1111, 4'b0001, {3'd4,3'd3,3'd2,3'd0}, 3'd5}, // R4 second pair plain
    '{5'b11111, {2'd1,2'd0,2'd0,2'd0,2'd0}, 4'b1111, 4'b0000, {3'd3,3'd2,3'd1,3'd0}, 3'd4}, // R5 compare beyond slots
    '{5'b00011, {2'd0,2'd0,2'd0,2'd1,2'd0}, 4'b0011, 4'b0000, {3'd0,3'd0,3'd1,3'd0}, 3'd2}, // R6 lone compare
    '{5'b11111, {2'd0,2'd0,2'd0,2'd1,2'd3}, 4'b1111, 4'b0000, {3'd3,3'd2,3'd1,3'd0}, 3'd4}, // R2 branch first
    '{5'b00000, {2'd0,2'd0,2'd0,2'd0,2'd0}, 4'b0000, 4'b0000, {3'd0,3'd0,3'd0,3'd0}, 3'd0}, // R9 empty
    '{5'b00101, {2'd0,2'd0,2'd3,2'd0,2'd1}, 4'b0001, 4'b0000, {3'd0,3'd0,3'd0,3'd0}, 3'd1}, // R9 gap
    '{5'b11111, {2'd0,2'd0,2'd3,2'd2,2'd0}, 4'b1111, 4'b0010, {3'd4,3'd3,3'd1,3'd0}, 3'd5}, // R2 test fuse
    '{5'b00011, {2'd0,2'd0,2'd0,2'd3,2'd1}, 4'b0001, 4'b0001, {3'd0,3'd0,3'd0,3'd0}, 3'd2}, // R3 short pair
    '{5'b11111, {2'd0,2'd0,2'd3,2'd0,2'd2}, 4'b1111, 4'b0000, {3'd3,3'd2,3'd1,3'd0}, 3'd4}  // R2 not adjacent
  };

  logic clk = 1'b0;
  logic rstN;
  logic [WIN-1:0]       inValid;
  logic [2*WIN-1:0]     inCls;
  logic [WIN*OPW-1:0]   inOpA;
  logic [WIN*OPW-1:0]   inOpB;
  logic [WIN*TGW-1:0]   inTgt;
  logic                 outReady;
  logic [SLOTS-1:0]     uopValid, uopFused, hValid, hFused;
  logic [2*SLOTS-1:0]   uopCls, hCls;
  logic [SLOTS*OPW-1:0] uopOpA, uopOpB, hOpA, hOpB;
  logic [SLOTS*TGW-1:0] uopTgt, hTgt;
  logic [2:0]           takeCount, hTake;

  int nCmp = 0;
  int nBad = 0;

  always #5 clk = ~clk;

  fuse_decode #(.SLOTS(SLOTS), .OPW(OPW), .TGW(TGW), .HOLD_BACK(0)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inCls(inCls), .inOpA(inOpA),
    .inOpB(inOpB), .inTgt(inTgt), .outReady(outReady), .uopValid(uopValid),
    .uopFused(uopFused), .uopCls(uopCls), .uopOpA(uopOpA), .uopOpB(uopOpB),
    .uopTgt(uopTgt), .takeCount(takeCount));

  fuse_decode #(.SLOTS(SLOTS), .OPW(OPW), .TGW(TGW), .HOLD_BACK(1)) dutHold (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inCls(inCls), .inOpA(inOpA),
    .inOpB(inOpB), .inTgt(inTgt), .outReady(outReady), .uopValid(hValid),
    .uopFused(hFused), .uopCls(hCls), .uopOpA(hOpA), .uopOpB(hOpB),
    .uopTgt(hTgt), .takeCount(hTake));

  task automatic chk(input string req, input string what, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] vld, input logic [9:0] cls, input logic rdy);
    @(posedge clk);
    #1;
    inValid  = vld;
    inCls    = cls;
    outReady = rdy;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    nBad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    rstN     = 1'b0;
    inValid  = '0;
    inCls    = '0;
    outReady = 1'b1;
    for (int i = 0; i < WIN; i++) begin
      inOpA[i*OPW +: OPW] = OPW'(8'h10 + i);
      inOpB[i*OPW +: OPW] = OPW'(8'h20 + i);
      inTgt[i*TGW +: TGW] = TGW'(12'h300 + i);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9", "reset count", int'(takeCount), 0);
    chk("R9", "reset valid", int'(uopValid), 0);
    @(posedge clk);
    #1 rstN = 1'b1;

    for (int v = 0; v < 12; v++) begin
      drive(VECS[v].vld, VECS[v].cls, 1'b1);
      chk("R5", "count", int'(takeCount), int'(VECS[v].eCnt));
      chk("R1", "valid", int'(uopValid), int'(VECS[v].eV));
      chk("R2", "fused", int'(uopFused), int'(VECS[v].eF));
      for (int s = 0; s < SLOTS; s++) begin
        if (VECS[v].eV[s]) begin
          int src;
          src = int'(VECS[v].eSrc[3*s +: 3]);
          chk("R3", "cls", int'(uopCls[2*s +: 2]), int'(VECS[v].cls[2*src +: 2]));
          chk("R3", "opA", int'(uopOpA[s*OPW +: OPW]), 8'h10 + src);
          chk("R3", "opB", int'(uopOpB[s*OPW +: OPW]), 8'h20 + src);
          chk("R3", "tgt", int'(uopTgt[s*TGW +: TGW]),
              12'h300 + src + (VECS[v].eF[s] ? 1 : 0));
        end
      end
    end

    // R8: stall keeps micro-ops and consumes nothing.
    drive(5'b11111, {2'd0,2'd0,2'd0,2'd3,2'd1}, 1'b0);
    chk("R8", "stall count", int'(takeCount), 0);
    chk("R8", "stall valid", int'(uopValid), 4'b1111);
    chk("R8", "stall fused", int'(uopFused), 4'b0001);
    drive(5'b11111, {2'd0,2'd0,2'd0,2'd3,2'd1}, 1'b0);
    chk("R8", "stall count 2", int'(takeCount), 0);
    chk("R8", "stall fused 2", int'(uopFused), 4'b0001);
    drive(5'b11111, {2'd0,2'd0,2'd0,2'd3,2'd1}, 1'b1);
    chk("R8", "release count", int'(takeCount), 5);

    // R7: hold-back instance; R6 default instance decodes alone.
    drive(5'b00011, {2'd0,2'd0,2'd0,2'd1,2'd0}, 1'b1);
    chk("R7", "hold count", int'(hTake), 1);
    chk("R7", "hold valid", int'(hValid), 4'b0001);
    chk("R6", "no hold count", int'(takeCount), 2);
    drive(5'b00001, {2'd0,2'd0,2'd0,2'd0,2'd1}, 1'b1);
    chk("R7", "after hold count", int'(hTake), 1);
    chk("R7", "after hold valid", int'(hValid), 4'b0001);
    chk("R7", "after hold fused", int'(hFused), 0);
    drive(5'b00001, {2'd0,2'd0,2'd0,2'd0,2'd1}, 1'b1);
    chk("R7", "rehold count", int'(hTake), 0);
    chk("R7", "rehold valid", int'(hValid), 0);
    drive(5'b00011, {2'd0,2'd0,2'd0,2'd3,2'd1}, 1'b1);
    chk("R7", "late pair count", int'(hTake), 2);
    chk("R7", "late pair fused", int'(hFused), 4'b0001);
    chk("R3", "late pair tgt", int'(hTgt[TGW-1:0]), 12'h301);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule